// File: doc/BRIEF.md
# Condition-prefix predication and status unit

This unit is the flag and predication slice of a small processor core. It keeps a four-bit arithmetic flag register that the ALU updates through a write enable. A compare is simply an ALU operation that writes flags and no destination register. No general-purpose register access reaches these flags. Conditional jumps and a one-shot condition prefix both test the flags against a four-bit condition code.

The prefix takes no operands. It decides, at the moment it issues, whether the single instruction after it runs. It carries a copy of that instruction's length bits, so a failed condition retires the prefix and the skipped instruction together in two cycles. A passing condition adds one cycle to the predicated instruction.

Three status bits sit beside the flags: interrupt enable, single step and a sticky division error. Dedicated status instructions read and write them. For every issued instruction, the unit tells the sequencer three things in the same cycle: whether the instruction executes, whether a jump is taken, and how many cycles to charge.

Top module: `cond_status_unit`

## Requirements
- R1: After reset the flags, the pending prefix, interrupt enable, single step and division error are all zero. While `instr_valid` is low, `exec_en`, `branch_taken`, `cyc_count` and `stat_rdata` are zero.
- R2: The flags are written at the clock edge only when `instr_valid`, `exec_en` and `alu_flag_we` are all high. `alu_flags` is ordered {V,C,N,Z} from bit 3 down to bit 0.
- R3: Condition codes map as follows: 0 always, 1 Z, 2 !Z, 3 N^V, 4 !(N^V), 5 !C, 6 C, 7 N, 8 !N, 9 V, 10 !V, 11 !Z&(N==V), 12 Z|(N!=V), 13 C&!Z, 14 !C|Z, 15 never.
- R4: `op_kind` takes 0 for a plain instruction, 1 for a prefix, 2 for a jump and 3 for a status instruction. An instruction with no prefix pending executes and is charged 2+`ml` cycles.
- R5: A prefix whose condition passes is charged 0 cycles. The next non-prefix instruction executes and is charged 3+`ml` cycles.
- R6: A prefix whose condition fails is charged 2 cycles. The next non-prefix instruction has `exec_en` low, `cyc_count` 0 and `branch_taken` low. Its flag write and status write are discarded.
- R7: A prefix issued while another is pending replaces it. The new prefix is itself executed and evaluated alone, whatever the old result was.
- R8: A pending prefix survives cycles with `instr_valid` low. It applies to exactly one instruction.
- R9: `irq_entry` clears the pending prefix at the clock edge. This takes priority over a prefix that issues in the same cycle.
- R10: An executed jump raises `branch_taken` when its condition holds on the current flags. Its cycle charge follows R4/R5.
- R11: `stat_op` 0 reads and 1 writes the interrupt enable. Values 2 and 3 do the same for single step. A read returns the bit zero-extended on `stat_rdata`, and a write takes `reg_val` bit 0. The bits also drive `int_en` and `step_en`.
- R12: The division error bit is set by `div_err_set`. It is cleared by an executed `stat_op` 5 and read by `stat_op` 4. When set and clear coincide, set wins. No instruction can set it.
- R13: `stat_rdata` is zero except during an executed read status instruction (`stat_op` 0, 2 or 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction issues this cycle |
| op_kind | input | 2 | 0 plain, 1 prefix, 2 jump, 3 status |
| cond | input | 4 | Condition code for prefix or jump |
| ml | input | 2 | Length bits of the instruction (copy of next instruction's bits on a prefix) |
| stat_op | input | 3 | Status operation select |
| reg_val | input | DATA_W | Register operand for status writes |
| alu_flag_we | input | 1 | ALU requests a flag update |
| alu_flags | input | 4 | New flags {V,C,N,Z} |
| div_err_set | input | 1 | Divider reports an error |
| irq_entry | input | 1 | Interrupt entry is taken |
| exec_en | output | 1 | The issued instruction executes |
| branch_taken | output | 1 | The issued jump is taken |
| cyc_count | output | 3 | Cycles charged for the issued instruction |
| stat_rdata | output | DATA_W | Status read data |
| int_en | output | 1 | Interrupt enable bit |
| step_en | output | 1 | Single-step bit |

## Verification
Four outputs are combinational on the issuing cycle: `exec_en`, `branch_taken`, `cyc_count` and `stat_rdata`. The bench therefore drives each instruction after a falling edge and compares these outputs a few nanoseconds later, before the rising edge. Flag, status and pending-prefix effects take hold at that rising edge. The bench moves its reference model forward only after the edge, so each effect is first checked on the next issued instruction. `int_en` and `step_en` are compared on every cycle against the model's state from the previous edge.

// File: rtl/cond_status_unit.sv
module cond_status_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [1:0]        op_kind,
  input  logic [3:0]        cond,
  input  logic [1:0]        ml,
  input  logic [2:0]        stat_op,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              alu_flag_we,
  input  logic [3:0]        alu_flags,
  input  logic              div_err_set,
  input  logic              irq_entry,
  output logic              exec_en,
  output logic              branch_taken,
  output logic [2:0]        cyc_count,
  output logic [DATA_W-1:0] stat_rdata,
  output logic              int_en,
  output logic              step_en
);
  localparam logic [1:0] K_PLAIN = 2'd0, K_PFX = 2'd1, K_JMP = 2'd2, K_STAT = 2'd3;
  localparam logic [2:0] S_GINT = 3'd0, S_SINT = 3'd1, S_GSS = 3'd2, S_SSS = 3'd3,
                         S_GDE = 3'd4, S_CDE = 3'd5;

  logic [3:0] flags_q;
  logic       pend_q, pend_pass_q, div_err_q;
  logic       cond_ok, is_pfx, skipped, stat_wr;

  always_comb begin
    logic z, n, c, v;
    {v, c, n, z} = flags_q;
    unique case (cond)
      4'd0:  cond_ok = 1'b1;
      4'd1:  cond_ok = z;
      4'd2:  cond_ok = !z;
      4'd3:  cond_ok = n ^ v;
      4'd4:  cond_ok = !(n ^ v);
      4'd5:  cond_ok = !c;
      4'd6:  cond_ok = c;
      4'd7:  cond_ok = n;
      4'd8:  cond_ok = !n;
      4'd9:  cond_ok = v;
      4'd10: cond_ok = !v;
      4'd11: cond_ok = !z && (n == v);
      4'd12: cond_ok = z || (n != v);
      4'd13: cond_ok = c && !z;
      4'd14: cond_ok = !c || z;
      default: cond_ok = 1'b0;
    endcase
  end

  assign is_pfx       = op_kind == K_PFX;
  assign skipped      = pend_q && !pend_pass_q && !is_pfx;
  assign exec_en      = instr_valid && !skipped;
  assign branch_taken = exec_en && op_kind == K_JMP && cond_ok;
  assign stat_wr      = exec_en && op_kind == K_STAT;

  always_comb begin
    if (!exec_en)                  cyc_count = 3'd0;
    else if (is_pfx)               cyc_count = cond_ok ? 3'd0 : 3'd2;
    else if (pend_q && pend_pass_q) cyc_count = 3'd3 + {1'b0, ml};
    else                           cyc_count = 3'd2 + {1'b0, ml};
  end

  always_comb begin
    stat_rdata = '0;
    if (stat_wr) begin
      unique case (stat_op)
        S_GINT:  stat_rdata[0] = int_en;
        S_GSS:   stat_rdata[0] = step_en;
        S_GDE:   stat_rdata[0] = div_err_q;
        default: stat_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q     <= '0;
      pend_q      <= 1'b0;
      pend_pass_q <= 1'b0;
      int_en      <= 1'b0;
      step_en     <= 1'b0;
      div_err_q   <= 1'b0;
    end else begin
      if (exec_en && alu_flag_we) flags_q <= alu_flags;
      if (irq_entry) pend_q <= 1'b0;
      else if (instr_valid) begin
        pend_q      <= is_pfx;
        pend_pass_q <= is_pfx && cond_ok;
      end
      if (stat_wr && stat_op == S_SINT) int_en  <= reg_val[0];
      if (stat_wr && stat_op == S_SSS)  step_en <= reg_val[0];
      div_err_q <= div_err_set || (div_err_q && !(stat_wr && stat_op == S_CDE));
    end
  end
endmodule

// File: rtl/cond_status_unit_chk.sv
module cond_status_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [1:0]        op_kind,
  input logic [3:0]        cond,
  input logic [1:0]        ml,
  input logic [2:0]        stat_op,
  input logic [DATA_W-1:0] reg_val,
  input logic              alu_flag_we,
  input logic [3:0]        alu_flags,
  input logic              div_err_set,
  input logic              irq_entry,
  input logic              exec_en,
  input logic              branch_taken,
  input logic [2:0]        cyc_count,
  input logic [DATA_W-1:0] stat_rdata,
  input logic              int_en,
  input logic              step_en
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!exec_en && !branch_taken && cyc_count == 3'd0));

  p_fail_skips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && op_kind == 2'd1 && cyc_count == 3'd2 && !irq_entry)
    |=> !(instr_valid && op_kind != 2'd1 && exec_en));

  p_irq_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_entry) |-> (exec_en == instr_valid));

  p_branch_needs_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> (exec_en && op_kind == 2'd2));

  p_rdata_on_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata != '0) |-> (exec_en && op_kind == 2'd3 && !stat_op[0]));

  p_int_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exec_en && op_kind == 2'd3 && stat_op == 3'd1) |-> $stable(int_en));

  p_step_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exec_en && op_kind == 2'd3 && stat_op == 3'd3) |-> $stable(step_en));

  p_clear_de_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exec_en && op_kind == 2'd3 && stat_op == 3'd5 && !div_err_set) &&
     exec_en && op_kind == 2'd3 && stat_op == 3'd4) |-> (stat_rdata == '0));

  p_exec_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_kind != 2'd1) |-> (cyc_count >= 3'd2));
endmodule

bind cond_status_unit cond_status_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cond_status_unit_bench.sv
module cond_status_unit_bench;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 0, alu_flag_we = 0, div_err_set = 0, irq_entry = 0;
  logic [1:0] op_kind = 0, ml = 0;
  logic [3:0] cond = 0, alu_flags = 0;
  logic [2:0] stat_op = 0;
  logic [DW-1:0] reg_val = 0;
  logic exec_en, branch_taken, int_en, step_en;
  logic [2:0] cyc_count;
  logic [DW-1:0] stat_rdata;

  int checks = 0, errors = 0, cycles = 0;
  int fz = 0, fn = 0, fc = 0, fv = 0;
  int pend = 0, ppass = 0, m_ie = 0, m_ss = 0, m_de = 0;

  always #10 clk = ~clk;

  cond_status_unit #(.DATA_W(DW)) u_cond_status_unit (.*);

  function automatic int truth(input int c);
    case (c)
      0: return 1;            1: return fz;
      2: return !fz;          3: return fn != fv;
      4: return fn == fv;     5: return !fc;
      6: return fc;           7: return fn;
      8: return !fn;          9: return fv;
      10: return !fv;         11: return !fz && fn == fv;
      12: return fz || fn != fv; 13: return fc && !fz;
      14: return !fc || fz;   default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input int v, input int k, input int c, input int l, input int so,
                       input int rv, input int we, input int fl, input int de, input int irq,
                       input string req);
    int e_ex, e_br, e_cy, e_rd, pfx, ok;
    @(negedge clk);
    instr_valid = v[0]; op_kind = k[1:0]; cond = c[3:0]; ml = l[1:0]; stat_op = so[2:0];
    reg_val = rv[DW-1:0]; alu_flag_we = we[0]; alu_flags = fl[3:0];
    div_err_set = de[0]; irq_entry = irq[0];
    pfx = (k == 1); ok = truth(c);
    e_ex = v && !(pend && !ppass && !pfx);
    e_br = e_ex && k == 2 && ok;
    e_cy = !e_ex ? 0 : pfx ? (ok ? 0 : 2) : (pend && ppass) ? 3 + l : 2 + l;
    e_rd = 0;
    if (e_ex && k == 3) e_rd = (so == 0) ? m_ie : (so == 2) ? m_ss : (so == 4) ? m_de : 0;
    #5;
    chk({req, " exec"}, exec_en, e_ex);
    chk({req, " branch"}, branch_taken, e_br);
    chk({req, " cycles"}, cyc_count, e_cy);
    chk({req, " rdata"}, int'(stat_rdata), e_rd);
    chk({req, " int_en"}, int_en, m_ie);
    chk({req, " step_en"}, step_en, m_ss);
    @(posedge clk);
    if (e_ex && we) begin fz = fl & 1; fn = (fl >> 1) & 1; fc = (fl >> 2) & 1; fv = (fl >> 3) & 1; end
    if (irq) pend = 0;
    else if (v) begin pend = pfx; ppass = pfx && ok; end
    if (e_ex && k == 3 && so == 1) m_ie = rv & 1;
    if (e_ex && k == 3 && so == 3) m_ss = rv & 1;
    m_de = de || (m_de && !(e_ex && k == 3 && so == 5));
  endtask

  task automatic idle(input string req);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic plain(input int l, input int we, input int fl, input string req);
    issue(1, 0, 0, l, 0, 0, we, fl, 0, 0, req);
  endtask
  task automatic pfx(input int c, input int l, input string req);
    issue(1, 1, c, l, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic jmp(input int c, input int l, input string req);
    issue(1, 2, c, l, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic stat(input int so, input int rv, input int de, input string req);
    issue(1, 3, 0, 0, so, rv, 0, 0, de, 0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1 reset idle");
    jmp(1, 0, "R1 flags zero at reset");
    stat(0, 0, 0, "R1 int_en reset");
    stat(2, 0, 0, "R1 step reset");
    stat(4, 0, 0, "R1 diverr reset");
    for (int f = 0; f < 16; f++) begin
      plain(f % 4, 1, f, "R2 compare writes flags");
      for (int c = 0; c < 16; c++) jmp(c, c % 4, "R3 R10 condition jump");
    end
    plain(1, 0, 4'b0001, "R2 no write without enable");
    jmp(1, 0, "R2 flags kept");
    plain(0, 1, 4'b0001, "R2 set Z");
    pfx(1, 2, "R5 passing prefix");
    plain(2, 0, 0, "R5 predicated charge");
    plain(2, 0, 0, "R8 only one instruction");
    pfx(2, 1, "R6 failing prefix");
    plain(1, 1, 4'b0000, "R6 skipped flag write");
    jmp(1, 0, "R6 flags unchanged");
    pfx(2, 0, "R8 failing prefix then idle");
    idle("R8 idle keeps pending");
    idle("R8 idle keeps pending");
    jmp(0, 0, "R8 R6 skipped jump");
    pfx(2, 0, "R7 failing prefix");
    pfx(0, 0, "R7 replacing prefix");
    plain(3, 0, 0, "R7 runs under new prefix");
    pfx(1, 0, "R7 passing prefix");
    pfx(2, 0, "R7 failing replaces pass");
    plain(0, 0, 0, "R7 skipped");
    pfx(2, 0, "R9 failing prefix");
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 irq entry");
    plain(0, 0, 0, "R9 runs after irq");
    issue(1, 1, 2, 0, 0, 0, 0, 0, 0, 1, "R9 irq with prefix");
    plain(1, 0, 0, "R9 prefix dropped");
    stat(1, 1, 0, "R11 set int");
    stat(0, 0, 0, "R11 get int");
    stat(3, 3, 0, "R11 set step");
    stat(2, 0, 0, "R11 get step");
    pfx(2, 0, "R6 failing before status");
    stat(1, 0, 0, "R6 skipped status write");
    stat(0, 0, 0, "R11 int kept");
    stat(3, 2, 0, "R11 bit0 only");
    stat(2, 0, 0, "R11 step cleared");
    issue(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R12 hw sets diverr");
    stat(4, 0, 0, "R12 read diverr");
    stat(5, 0, 0, "R12 clear diverr");
    stat(4, 0, 0, "R12 read cleared");
    stat(3, 1, 0, "R12 set-style op cannot set diverr");
    stat(4, 0, 0, "R12 still clear");
    stat(1, 1, 1, "R12 hw set");
    stat(5, 0, 1, "R12 set beats clear");
    stat(4, 0, 0, "R12 set won");
    stat(1, 1, 0, "R13 write returns zero");
    plain(0, 0, 0, "R13 plain returns zero");
    rst_n = 1'b0;
    @(posedge clk);
    fz = 0; fn = 0; fc = 0; fv = 0; pend = 0; ppass = 0; m_ie = 0; m_ss = 0; m_de = 0;
    #1 rst_n = 1'b1;
    stat(0, 0, 0, "R1 reset clears int");
    jmp(2, 0, "R1 reset clears flags");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule